// File: doc/BRIEF.md
# Two-Wire Bus Arbitration Loss Detector

This block watches a two-wire serial bus while the local node is acting as bus master. On each rising edge of the bus clock line it compares the level actually present on the bus data line with the level the node itself is putting out. Only a released (high) output can be overridden by another node, so only that case is compared. When another master holds the line low while this node has released it, the node has lost arbitration.

On a loss the block raises a sticky flag and drops the node to slave receiver by clearing both mode bits. It also withdraws the node's data and clock pull-down enables, so the node stops shaping the bus for the rest of the transfer. The flag remains set until software reads or writes the data buffer, or writes the control register. A control register write also loads new values for the two mode bits.

Both bus lines are brought into the local clock domain through a short synchronizer before they are used. Start and stop generation, the byte shift register and the bit counter sit outside this block.

Top module: `i2c_arb_guard`

## Requirements
- R1: SCL and SDA pass through a SYNC_STAGES-deep synchronizer (default 2, reset value 1). The comparison happens only in the single cycle that follows a rising edge of the synchronized SCL. A change of SDA while SCL stays high never causes a loss.
- R2: A loss is a synchronized rising SCL edge, while `mst`=1, with `sda_drive`=1 and synchronized SDA=0. `arb_lost` then reads 1 from the third clock edge after `scl_in` rises.
- R3: No loss is flagged when `sda_drive`=0, whatever the bus level, or when `mst`=0.
- R4: On the edge that sets `arb_lost`, `mst` and `trx` both become 0 (slave receiver).
- R5: `sda_oe` (1 = pull SDA low) equals NOT `sda_drive` while `arb_lost`=0, and is 0 while `arb_lost`=1.
- R6: `scl_oe` (1 = pull SCL low) is 1 only when `mst`=1, `arb_lost`=0 and `scl_drive`=0. It is therefore 0 while `arb_lost`=1.
- R7: `arb_lost` holds its value until a one-cycle pulse on `dbr_rd`, `dbr_wr` or `ctrl_wr`, which clears it on the next edge.
- R8: When a loss and a clearing strobe (including `ctrl_wr`) fall in the same cycle, the loss wins: `arb_lost`=1, `mst`=0, `trx`=0.
- R9: `ctrl_wr` loads `mst` from `mst_wdata` and `trx` from `trx_wdata` on the next edge.
- R10: After reset, `arb_lost`, `mst`, `trx`, `scl_oe` and `sda_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_drive | input | 1 | Data level the node wants on SDA (1 = released) |
| scl_drive | input | 1 | Clock level the node's generator wants on SCL (1 = released) |
| mst_wdata | input | 1 | Master mode value for a control write |
| trx_wdata | input | 1 | Transmitter mode value for a control write |
| ctrl_wr | input | 1 | Control register write strobe |
| dbr_rd | input | 1 | Data buffer read strobe |
| dbr_wr | input | 1 | Data buffer write strobe |
| arb_lost | output | 1 | Arbitration lost flag |
| mst | output | 1 | Master mode bit |
| trx | output | 1 | Transmitter mode bit |
| scl_oe | output | 1 | Pull SCL low enable |
| sda_oe | output | 1 | Pull SDA low enable |

## Verification
Two functions can meet in one cycle: the setting of the loss flag and its clearing by a software strobe. A control write that reloads the mode bits can also land in the same cycle as a loss. The bench provokes both by counting clock edges from the `scl_in` rise and placing `ctrl_wr` or `dbr_rd` in exactly the cycle where the synchronized edge is compared. It then expects the flag set and both mode bits cleared. Other checks place a strobe well away from any edge, so that a clear with no loss present is also seen.

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic sda_drive,
  input  logic scl_drive,
  input  logic mst_wdata,
  input  logic trx_wdata,
  input  logic ctrl_wr,
  input  logic dbr_rd,
  input  logic dbr_wr,
  output logic arb_lost,
  output logic mst,
  output logic trx,
  output logic scl_oe,
  output logic sda_oe
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sh, sda_sh;
  logic         scl_q;
  logic         scl_rise, lose, clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[TOP-1:0], scl_in};
      sda_sh <= {sda_sh[TOP-1:0], sda_in};
      scl_q  <= scl_sh[TOP];
    end
  end

  assign scl_rise = scl_sh[TOP] & ~scl_q;
  assign lose     = scl_rise & mst & sda_drive & ~sda_sh[TOP];
  assign clr      = dbr_rd | dbr_wr | ctrl_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arb_lost <= 1'b0;
      mst      <= 1'b0;
      trx      <= 1'b0;
    end else if (lose) begin
      arb_lost <= 1'b1;
      mst      <= 1'b0;
      trx      <= 1'b0;
    end else begin
      if (clr) arb_lost <= 1'b0;
      if (ctrl_wr) begin
        mst <= mst_wdata;
        trx <= trx_wdata;
      end
    end
  end

  assign sda_oe = ~sda_drive & ~arb_lost;
  assign scl_oe = ~scl_drive & mst & ~arb_lost;

endmodule

// File: rtl/i2c_arb_guard_chk.sv
module i2c_arb_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_rise,
  input logic arb_lost,
  input logic mst,
  input logic trx,
  input logic scl_oe,
  input logic sda_oe,
  input logic dbr_rd,
  input logic dbr_wr,
  input logic ctrl_wr
);

  // R2
  rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> $past(scl_rise));

  // R3
  slave_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mst |=> !$rose(arb_lost));

  // R4
  mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!mst && !trx));

  // R5
  sda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !sda_oe);

  // R6
  scl_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !scl_oe);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !scl_rise && (dbr_rd || dbr_wr || ctrl_wr)) |=> !arb_lost);

endmodule

bind i2c_arb_guard i2c_arb_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .arb_lost(arb_lost),
  .mst(mst), .trx(trx), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .dbr_rd(dbr_rd), .dbr_wr(dbr_wr), .ctrl_wr(ctrl_wr)
);

// File: tb/test_i2c_arb_guard.sv
module test_i2c_arb_guard;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_in, sda_in, sda_drive, scl_drive;
  logic mst_wdata, trx_wdata, ctrl_wr, dbr_rd, dbr_wr;
  logic arb_lost, mst, trx, scl_oe, sda_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  string      tag_q[$];
  logic [4:0] val_q[$];
  event       chk_ev;

  always #10 clk = ~clk;

  i2c_arb_guard i_i2c_arb_guard (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_drive(sda_drive), .scl_drive(scl_drive), .mst_wdata(mst_wdata),
    .trx_wdata(trx_wdata), .ctrl_wr(ctrl_wr), .dbr_rd(dbr_rd), .dbr_wr(dbr_wr),
    .arb_lost(arb_lost), .mst(mst), .trx(trx), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // monitor: compares outputs {arb_lost,mst,trx,scl_oe,sda_oe} against queued items
  initial begin
    forever begin
      @(chk_ev);
      while (val_q.size() > 0) begin
        string      t;
        logic [4:0] e;
        logic [4:0] a;
        t = tag_q.pop_front();
        e = val_q.pop_front();
        a = {arb_lost, mst, trx, scl_oe, sda_oe};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: got %b expected %b", t, a, e);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string t, logic a, logic m, logic x, logic so, logic dd);
    tag_q.push_back(t);
    val_q.push_back({a, m, x, so, dd});
    -> chk_ev;
    #1;
  endtask

  task automatic bus_bit(logic drv, logic bus);
    scl_in = 1'b0;
    tick(3);
    sda_in = bus;
    sda_drive = drv;
    tick(2);
    scl_in = 1'b1;
    tick(4);
  endtask

  task automatic ctrl(logic m, logic x);
    mst_wdata = m; trx_wdata = x; ctrl_wr = 1'b1;
    tick(1);
    ctrl_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; sda_drive = 1'b1; scl_drive = 1'b1;
    mst_wdata = 1'b0; trx_wdata = 1'b0; ctrl_wr = 1'b0; dbr_rd = 1'b0; dbr_wr = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_out("R10 reset state", 0, 0, 0, 0, 0);

    ctrl(1, 1);
    expect_out("R9 load master transmitter", 0, 1, 1, 0, 0);
    scl_drive = 1'b0; sda_drive = 1'b0;
    tick(1);
    expect_out("R6 R5 enables while master", 0, 1, 1, 1, 1);

    bus_bit(1, 1);
    expect_out("R2 released and high matches", 0, 1, 1, 1, 0);
    bus_bit(0, 0);
    expect_out("R3 driven low matches", 0, 1, 1, 1, 1);
    bus_bit(0, 1);
    expect_out("R3 driven low not compared", 0, 1, 1, 1, 1);

    bus_bit(1, 1);
    sda_in = 1'b0;
    tick(5);
    expect_out("R1 SDA fall with SCL high ignored", 0, 1, 1, 1, 0);
    sda_in = 1'b1;

    bus_bit(1, 0);
    expect_out("R2 R4 loss drops to slave receiver", 1, 0, 0, 0, 0);
    sda_drive = 1'b0;
    tick(1);
    expect_out("R5 R6 SDA released and clock stopped", 1, 0, 0, 0, 0);
    tick(10);
    expect_out("R7 flag holds without strobe", 1, 0, 0, 0, 0);

    dbr_rd = 1'b1; tick(1); dbr_rd = 1'b0;
    expect_out("R7 data read clears flag", 0, 0, 0, 0, 1);

    bus_bit(1, 0);
    expect_out("R3 no compare while slave", 0, 0, 0, 0, 0);

    ctrl(1, 0);
    expect_out("R9 load master receiver", 0, 1, 0, 1, 0);
    bus_bit(1, 0);
    expect_out("R4 loss as master receiver", 1, 0, 0, 0, 0);
    dbr_wr = 1'b1; tick(1); dbr_wr = 1'b0;
    expect_out("R7 data write clears flag", 0, 0, 0, 0, 0);

    ctrl(1, 1);
    bus_bit(1, 0);
    expect_out("R2 second loss", 1, 0, 0, 0, 0);
    ctrl(1, 1);
    expect_out("R7 R9 control write clears and reloads", 0, 1, 1, 1, 0);

    // same-cycle: control write in the compare cycle
    scl_in = 1'b0; tick(3);
    sda_in = 1'b0; sda_drive = 1'b1; tick(2);
    scl_in = 1'b1; tick(2);
    mst_wdata = 1'b1; trx_wdata = 1'b1; ctrl_wr = 1'b1;
    tick(1); ctrl_wr = 1'b0;
    expect_out("R8 loss beats control write", 1, 0, 0, 0, 0);
    tick(3);

    // same-cycle: data read in the compare cycle
    ctrl(1, 1);
    sda_in = 1'b1;
    scl_in = 1'b0; tick(3);
    sda_in = 1'b0; tick(2);
    scl_in = 1'b1; tick(2);
    dbr_rd = 1'b1;
    tick(1); dbr_rd = 1'b0;
    expect_out("R8 loss beats data read", 1, 0, 0, 0, 0);

    tick(2);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule